// File: doc/BRIEF.md
# Reference Divider and Phase Comparator

This block produces the reference timing for a frequency synthesizer and compares it against a pulse train taken from the divided local oscillator. A counter divides the 75 kHz crystal clock by one of six ratios. A 3-bit select code picks the ratio, which gives reference rates of 1, 3, 5, 6.25, 12.5 and 25 kHz. Two select codes stop the reference altogether.

Both pulse trains feed a two-state phase-frequency detector. The charge-pump control is presented as an output-enable and a level. An oscillator edge that arrives first drives the pump high. A reference edge that arrives first drives it low. With no pending error the pump floats.

A dead-band select chooses between two modes. In one mode every error reaches the pump. In the other mode an error state must persist before it is passed on. A length counter on the error state also feeds a sticky unlock flag, which the controller clears by strobing a read input. When the loop is stopped, or the device is halted or in backup, the pump floats and the detector and divider are cleared.

Top module: `ref_phase_cmp`

## Requirements
- R1: After reset, pump_oe, pump_level and unlock_flag are all 0.
- R2: Select codes 0, 1, 2, 3, 4 and 5 divide the clock by 75, 25, 15, 12, 6 and 3. The first reference tick falls in the cycle whose counter value is ratio-1. Counting from the first running cycle, the detector therefore registers that tick at the ratio-th clock edge, and ticks then repeat every ratio cycles.
- R3: Select codes 6 and 7 produce no reference ticks. With no oscillator pulses, the pump then stays floating (pump_oe = 0).
- R4: An oscillator pulse with no pending reference error drives the pump high (pump_oe = 1, pump_level = 1) from the clock edge that samples it. The drive holds until a reference tick arrives.
- R5: A reference tick with no pending oscillator error drives the pump low (pump_oe = 1, pump_level = 0).
- R6: When the two pulses cancel, no error remains. This covers pulses in the same cycle, and a second pulse that arrives while the opposite error is pending. The up and down states are never both set.
- R7: While pll_stop, halt or backup is 1, pump_oe is 0 in that same cycle. At the next edge the detector state, the error length and the reference counter are cleared. Whenever pump_oe is 0, pump_level is 0.
- R8: With db_mode = 0, every error state reaches the pump, including one that lasts a single cycle.
- R9: With db_mode = 1, the pump is driven only from the second consecutive cycle of an error state onward. An error state that lasts a single cycle never drives it.
- R10: An error state present in five consecutive cycles sets unlock_flag at the following edge. An error state of four cycles or fewer leaves the flag clear.
- R11: unlock_flag stays set until flag_rd is 1 at a clock edge, which clears it. If the set condition is present at that same edge, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal clock (75 kHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_sel | input | 3 | Reference ratio select code |
| osc_tick | input | 1 | One-cycle pulse from the divided oscillator, synchronous to clk |
| db_mode | input | 1 | Dead-band select: 0 passes all errors, 1 needs two cycles |
| pll_stop | input | 1 | Loop stopped |
| halt | input | 1 | Device in halt state |
| backup | input | 1 | Device in backup state |
| flag_rd | input | 1 | Read strobe that clears the unlock flag |
| pump_oe | output | 1 | Charge-pump drive enable (0 = high impedance) |
| pump_level | output | 1 | Charge-pump drive level when enabled (1 = high) |
| unlock_flag | output | 1 | Sticky loss-of-lock indication |

## Verification
The bench builds the block with its default parameters: the six ratios 75, 25, 15, 12, 6 and 3, a two-cycle dead band and a four-cycle unlock limit. The ratio of 3 puts reference ticks every third cycle, so coincident pulses, one-cycle errors and four- versus five-cycle errors can be placed exactly. The stopped-reference codes hold an oscillator error for as long as needed, which reaches the dead-band threshold, the unlock limit and the case where a set competes with a read.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
   localparam int SEL_W = 3;

   typedef enum logic [1:0] {
      DRV_FLOAT = 2'd0,
      DRV_HIGH  = 2'd1,
      DRV_LOW   = 2'd2
   } drive_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/rpc_refdiv.sv
module rpc_refdiv #(
   parameter int          SEL_W     = 3,
   parameter int          REF_CODES = 6,
   parameter int unsigned REF_DIV [REF_CODES] = '{75, 25, 15, 12, 6, 3}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             idle,
   input  logic [SEL_W-1:0] ref_sel,
   output logic             ref_tick
);
   function automatic int unsigned div_max();
      int unsigned m;
      m = 2;
      for (int i = 0; i < REF_CODES; i++)
         if (REF_DIV[i] > m) m = REF_DIV[i];
      return m;
   endfunction

   localparam int unsigned DIV_MAX = div_max();
   localparam int          CNT_W   = $clog2(DIV_MAX);

   logic [REF_CODES-1:0] code_hit;
   logic [CNT_W-1:0]     limit;
   logic                 code_ok;
   logic [CNT_W-1:0]     cnt;
   logic [SEL_W-1:0]     sel_q;
   logic                 sel_same;
   logic                 at_limit;

   // one decoder slice per supported code, each with its own range check
   for (genvar g = 0; g < REF_CODES; g++) begin : g_code
      if (REF_DIV[g] < 2) begin : g_bad
         $error("rpc_refdiv: ratio for code %0d must be at least 2", g);
      end
      assign code_hit[g] = (ref_sel == SEL_W'(g));
   end

   always_comb begin
      limit   = '0;
      code_ok = 1'b0;
      for (int i = 0; i < REF_CODES; i++) begin
         if (code_hit[i]) begin
            limit   = CNT_W'(REF_DIV[i] - 1);
            code_ok = 1'b1;
         end
      end
   end

   assign sel_same = (ref_sel == sel_q);
   assign at_limit = (cnt == limit);
   assign ref_tick = !idle && code_ok && sel_same && at_limit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         sel_q <= '0;
      end else begin
         sel_q <= ref_sel;
         if (idle || !code_ok || !sel_same || at_limit)
            cnt <= '0;
         else
            cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/rpc_pfd.sv
module rpc_pfd #(
   parameter int LEN_MAX = 5,
   parameter int LEN_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             idle,
   input  logic             ref_tick,
   input  logic             osc_tick,
   output logic             up_q,
   output logic             dn_q,
   output logic [LEN_W-1:0] err_len
);
   logic             up_n;
   logic             dn_n;
   logic [LEN_W-1:0] len_n;

   always_comb begin
      up_n = up_q | osc_tick;
      dn_n = dn_q | ref_tick;
      if (up_n && dn_n) begin
         up_n = 1'b0;
         dn_n = 1'b0;
      end
      if (up_n || dn_n)
         len_n = (err_len == LEN_W'(LEN_MAX)) ? err_len : err_len + 1'b1;
      else
         len_n = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || idle) begin
         up_q    <= 1'b0;
         dn_q    <= 1'b0;
         err_len <= '0;
      end else begin
         up_q    <= up_n;
         dn_q    <= dn_n;
         err_len <= len_n;
      end
   end
endmodule

// File: rtl/rpc_pump.sv
module rpc_pump
   import rpc_pkg::*;
#(
   parameter int DB_MIN = 2,
   parameter int LEN_W  = 3
) (
   input  logic             idle,
   input  logic             db_mode,
   input  logic             up_q,
   input  logic             dn_q,
   input  logic [LEN_W-1:0] err_len,
   output logic             pump_oe,
   output logic             pump_level
);
   logic   long_enough;
   drive_e drv;

   if (DB_MIN <= 1) begin : g_no_band
      assign long_enough = 1'b1;
   end else begin : g_band
      assign long_enough = (err_len >= LEN_W'(DB_MIN));
   end

   always_comb begin
      drv = DRV_FLOAT;
      if (!idle && (!db_mode || long_enough)) begin
         if (up_q)      drv = DRV_HIGH;
         else if (dn_q) drv = DRV_LOW;
      end
   end

   assign pump_oe    = (drv != DRV_FLOAT);
   assign pump_level = (drv == DRV_HIGH);
endmodule

// File: rtl/rpc_unlock.sv
module rpc_unlock #(
   parameter int UNLOCK_LEN = 4,
   parameter int LEN_W      = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flag_rd,
   input  logic [LEN_W-1:0] err_len,
   output logic             unlock_flag
);
   logic over;

   assign over = (err_len > LEN_W'(UNLOCK_LEN));

   always_ff @(posedge clk) begin
      if (!rst_n)       unlock_flag <= 1'b0;
      else if (over)    unlock_flag <= 1'b1;
      else if (flag_rd) unlock_flag <= 1'b0;
   end
endmodule

// File: rtl/ref_phase_cmp.sv
module ref_phase_cmp
   import rpc_pkg::*;
#(
   parameter int          REF_CODES  = 6,
   parameter int unsigned REF_DIV [REF_CODES] = '{75, 25, 15, 12, 6, 3},
   parameter int          DB_MIN     = 2,
   parameter int          UNLOCK_LEN = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] ref_sel,
   input  logic             osc_tick,
   input  logic             db_mode,
   input  logic             pll_stop,
   input  logic             halt,
   input  logic             backup,
   input  logic             flag_rd,
   output logic             pump_oe,
   output logic             pump_level,
   output logic             unlock_flag
);
   localparam int LEN_MAX = max2(UNLOCK_LEN, DB_MIN) + 1;
   localparam int LEN_W   = $clog2(LEN_MAX + 1);

   if (REF_CODES < 1 || REF_CODES > (1 << SEL_W)) begin : g_bad_codes
      $error("ref_phase_cmp: REF_CODES must fit the select field");
   end
   if (DB_MIN < 1) begin : g_bad_db
      $error("ref_phase_cmp: DB_MIN must be at least 1");
   end
   if (UNLOCK_LEN < 1) begin : g_bad_unlock
      $error("ref_phase_cmp: UNLOCK_LEN must be at least 1");
   end

   logic             idle;
   logic             ref_tick;
   logic             up_q;
   logic             dn_q;
   logic [LEN_W-1:0] err_len;

   assign idle = pll_stop | halt | backup;

   rpc_refdiv #(.SEL_W(SEL_W), .REF_CODES(REF_CODES), .REF_DIV(REF_DIV)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .idle     (idle),
      .ref_sel  (ref_sel),
      .ref_tick (ref_tick)
   );

   rpc_pfd #(.LEN_MAX(LEN_MAX), .LEN_W(LEN_W)) u_pfd (
      .clk      (clk),
      .rst_n    (rst_n),
      .idle     (idle),
      .ref_tick (ref_tick),
      .osc_tick (osc_tick),
      .up_q     (up_q),
      .dn_q     (dn_q),
      .err_len  (err_len)
   );

   rpc_pump #(.DB_MIN(DB_MIN), .LEN_W(LEN_W)) u_pump (
      .idle       (idle),
      .db_mode    (db_mode),
      .up_q       (up_q),
      .dn_q       (dn_q),
      .err_len    (err_len),
      .pump_oe    (pump_oe),
      .pump_level (pump_level)
   );

   rpc_unlock #(.UNLOCK_LEN(UNLOCK_LEN), .LEN_W(LEN_W)) u_unl (
      .clk         (clk),
      .rst_n       (rst_n),
      .flag_rd     (flag_rd),
      .err_len     (err_len),
      .unlock_flag (unlock_flag)
   );
endmodule

// File: rtl/rpc_checker.sv
module rpc_checker #(
   parameter int DB_MIN     = 2,
   parameter int UNLOCK_LEN = 4,
   localparam int LEN_MAX   = ((UNLOCK_LEN > DB_MIN) ? UNLOCK_LEN : DB_MIN) + 1,
   localparam int LEN_W     = $clog2(LEN_MAX + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             idle,
   input logic             db_mode,
   input logic             flag_rd,
   input logic             pump_oe,
   input logic             pump_level,
   input logic             unlock_flag,
   input logic             up_q,
   input logic             dn_q,
   input logic [LEN_W-1:0] err_len
);
   assert_float_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !pump_oe |-> !pump_level);

   assert_idle_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> !pump_oe);

   assert_idle_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      idle |=> (err_len == '0 && !up_q && !dn_q));

   assert_up_dn_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(up_q && dn_q));

   assert_band_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (db_mode && pump_oe) |-> (err_len >= LEN_W'(DB_MIN)));

   assert_flag_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlock_flag) |-> ($past(err_len) > LEN_W'(UNLOCK_LEN)));

   assert_read_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_rd && err_len <= LEN_W'(UNLOCK_LEN)) |=> !unlock_flag);

   assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (unlock_flag && !flag_rd) |=> unlock_flag);
endmodule

bind ref_phase_cmp rpc_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .idle        (idle),
   .db_mode     (db_mode),
   .flag_rd     (flag_rd),
   .pump_oe     (pump_oe),
   .pump_level  (pump_level),
   .unlock_flag (unlock_flag),
   .up_q        (up_q),
   .dn_q        (dn_q),
   .err_len     (err_len)
);

// File: tb/sim_ref_phase_cmp.sv
module sim_ref_phase_cmp;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] ref_sel = 3'd0;
   logic       osc_tick = 1'b0;
   logic       db_mode = 1'b0;
   logic       pll_stop = 1'b1;
   logic       halt = 1'b0;
   logic       backup = 1'b0;
   logic       flag_rd = 1'b0;
   logic       pump_oe;
   logic       pump_level;
   logic       unlock_flag;

   int n_vec = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   ref_phase_cmp u0 (
      .clk(clk), .rst_n(rst_n), .ref_sel(ref_sel), .osc_tick(osc_tick),
      .db_mode(db_mode), .pll_stop(pll_stop), .halt(halt), .backup(backup),
      .flag_rd(flag_rd), .pump_oe(pump_oe), .pump_level(pump_level),
      .unlock_flag(unlock_flag)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic park(input logic [2:0] code, input logic mode);
      pll_stop = 1'b1; ref_sel = code; db_mode = mode; osc_tick = 1'b0;
      step(1);
   endtask

   task automatic t_reset;
      chk("R1 oe", pump_oe, 0);
      chk("R1 level", pump_level, 0);
      chk("R1 flag", unlock_flag, 0);
   endtask

   task automatic t_ratios;
      int ratio [6] = '{75, 25, 15, 12, 6, 3};
      for (int c = 0; c < 6; c++) begin
         int n, m;
         park(3'(c), 1'b0);
         pll_stop = 1'b0;
         n = 0;
         do begin step(1); n++; end while (!pump_oe && n < 200);
         chk("R2 first tick", n, ratio[c]);
         chk("R5 low drive", pump_level, 0);
         osc_tick = 1'b1; step(1); osc_tick = 1'b0;
         chk("R6 late pulse cancels", pump_oe, 0);
         m = 0;
         do begin step(1); m++; end while (!pump_oe && m < 200);
         chk("R2 period", m, ratio[c] - 1);
         park(3'(c), 1'b0);
      end
   endtask

   task automatic t_no_ref;
      for (int c = 6; c < 8; c++) begin
         int bad;
         park(3'(c), 1'b0);
         pll_stop = 1'b0;
         bad = 0;
         for (int p = 0; p < 100; p++) begin step(1); if (pump_oe) bad++; end
         chk("R3 stopped ref", bad, 0);
      end
      park(3'd6, 1'b0);
   endtask

   task automatic t_up;
      park(3'd6, 1'b0);
      pll_stop = 1'b0;
      osc_tick = 1'b1; step(1); osc_tick = 1'b0;
      chk("R4 oe", pump_oe, 1);
      chk("R4 level", pump_level, 1);
      step(3);
      chk("R4 held", pump_oe, 1);
      pll_stop = 1'b1; step(1);
      chk("R7 stop floats", pump_oe, 0);
      chk("R7 level low", pump_level, 0);
      chk("R10 four cycles", unlock_flag, 0);
   endtask

   task automatic t_idle;
      for (int w = 0; w < 2; w++) begin
         park(3'd6, 1'b0);
         pll_stop = 1'b0;
         osc_tick = 1'b1; step(1); osc_tick = 1'b0;
         chk("R4 before idle", pump_oe, 1);
         if (w == 0) halt = 1'b1; else backup = 1'b1;
         #1;
         chk("R7 same cycle", pump_oe, 0);
         step(1);
         halt = 1'b0; backup = 1'b0;
         step(1);
         chk("R7 state cleared", pump_oe, 0);
      end
      park(3'd6, 1'b0);
   endtask

   task automatic t_match;
      int bad;
      park(3'd5, 1'b0);
      pll_stop = 1'b0;
      bad = 0;
      for (int p = 0; p < 30; p++) begin
         osc_tick = (p % 3 == 2);
         step(1);
         if (pump_oe) bad++;
      end
      osc_tick = 1'b0;
      chk("R6 coincident", bad, 0);
      park(3'd5, 1'b0);
   endtask

   task automatic t_band;
      for (int m = 0; m < 2; m++) begin
         int bad;
         park(3'd5, 1'(m));
         pll_stop = 1'b0;
         step(1);
         osc_tick = 1'b1; step(1); osc_tick = 1'b0;
         if (m == 0) begin
            chk("R8 one-cycle passes", pump_oe, 1);
            chk("R8 level", pump_level, 1);
         end else begin
            chk("R9 one-cycle blocked", pump_oe, 0);
         end
         bad = 0;
         for (int p = 0; p < 3; p++) begin step(1); if (pump_oe) bad++; end
         chk("R8 R9 cleared after tick", bad, 0);
      end
      park(3'd6, 1'b1);
      pll_stop = 1'b0;
      osc_tick = 1'b1; step(1); osc_tick = 1'b0;
      chk("R9 first cycle", pump_oe, 0);
      step(1);
      chk("R9 second cycle oe", pump_oe, 1);
      chk("R9 second cycle level", pump_level, 1);
      park(3'd6, 1'b0);
   endtask

   task automatic t_unlock;
      park(3'd4, 1'b0);
      flag_rd = 1'b1; step(1); flag_rd = 1'b0;
      pll_stop = 1'b0;
      step(1);
      osc_tick = 1'b1; step(1); osc_tick = 1'b0;
      step(5);
      chk("R10 four-cycle error", unlock_flag, 0);
      park(3'd4, 1'b0);
      pll_stop = 1'b0;
      osc_tick = 1'b1; step(1); osc_tick = 1'b0;
      step(4);
      chk("R10 before limit", unlock_flag, 0);
      step(1);
      chk("R10 five-cycle error", unlock_flag, 1);
      chk("R6 tick ends error", pump_oe, 0);
      pll_stop = 1'b1; step(4);
      chk("R11 sticky", unlock_flag, 1);
      flag_rd = 1'b1; step(1); flag_rd = 1'b0;
      chk("R11 read clears", unlock_flag, 0);
      step(1);
      chk("R11 stays clear", unlock_flag, 0);
      park(3'd6, 1'b0);
      pll_stop = 1'b0;
      osc_tick = 1'b1; step(1); osc_tick = 1'b0;
      step(5);
      chk("R10 long error", unlock_flag, 1);
      flag_rd = 1'b1; step(1); flag_rd = 1'b0;
      chk("R11 set beats read", unlock_flag, 1);
      pll_stop = 1'b1; step(1);
      flag_rd = 1'b1; step(1); flag_rd = 1'b0;
      chk("R11 read after stop", unlock_flag, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ratios();
      t_no_ref();
      t_up();
      t_idle();
      t_match();
      t_band();
      t_unlock();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got 0 expected 1 (run completion)");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule